// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block tells an out-of-order core whether a memory instruction has to wait for an older store that is still in flight. It keeps two linked tables. The set-ID table is indexed by a fold of the instruction address and names the store set the instruction belongs to. The last-store table is indexed by that set ID and holds the sequence number of the youngest store fetched into the set. Each entry in either table has its own valid bit.

The core issues one command per cycle on `op_i`. The commands are: look up a dependence, insert a load, insert a store, report that a store issued, report an ordering violation between a store address and a load address, and squash by sequence number. A lookup, or an insert of either kind, returns its answer on the following cycle as a valid flag and the sequence number of the store to wait for. Loads and stores are counted. When the count reaches the programmed clear period, both tables are wiped. This keeps old sets from growing until every store depends on every other.

Top module: `store_set_pred`

## Requirements
- R1: After reset, no entry of either table is valid, `dep_valid_o` is 0 and `dep_seq_o` is 0.
- R2: The set-ID table index is `(pc ^ (pc >> 10)) & (SSIT_ENTRIES-1)`. A newly allocated set ID is `(store_pc ^ (store_pc >> 10)) & (LFST_ENTRIES-1)`.
- R3: `op_i`=1 (lookup) reports on the next cycle. It gives `dep_valid_o`=1 with the last-store sequence number when the PC has a valid set ID whose last-store entry is valid. Otherwise it gives 0 with `dep_seq_o`=0. The tables are left unchanged.
- R4: `op_i`=3 (insert store) with a valid set ID reports the set's previous last-store entry, in the same way as R3, and then writes `seq_i` into that entry. A store with no set ID reports no dependence and changes nothing.
- R5: `op_i`=2 (insert load) reports in the same way as R3 and changes neither table.
- R6: `op_i`=5 (violation, store PC on `pc_i`, load PC on `pc_load_i`) maps both PCs to a new ID derived from the store PC (R2) when neither PC has a valid entry.
- R7: A violation in which only one of the two PCs has a valid entry copies that entry's ID to the other PC.
- R8: A violation in which both PCs have valid entries sets both to the smaller of the two IDs.
- R9: `op_i`=4 (store issued) invalidates the set's last-store entry only when that entry holds `seq_i`. A different sequence number has no effect.
- R10: `op_i`=6 (squash) invalidates every last-store entry whose sequence number is greater than `seq_i` and keeps older entries.
- R11: Inserts (op 2 and op 3) are counted. The insert that brings the count to a nonzero `clear_period_i` invalidates every entry of both tables, including any write made by that insert, and restarts the count. It still reports from the tables as they were before the wipe. A period of 0 disables clearing.
- R12: In the cycle after any other command (0, 4, 5, 6, 7), `dep_valid_o` is 0 and `dep_seq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Command: 0 none, 1 lookup, 2 insert load, 3 insert store, 4 store issued, 5 violation, 6 squash, 7 none |
| pc_i | input | PC_W | Instruction PC; store PC for a violation |
| pc_load_i | input | PC_W | Load PC for a violation |
| seq_i | input | SEQ_W | Sequence number of the instruction, or the squash point |
| clear_period_i | input | CNT_W | Number of inserts between wipes; 0 disables |
| dep_valid_o | output | 1 | Previous command found a store to wait for |
| dep_seq_o | output | SEQ_W | Sequence number of that store, 0 otherwise |

## Verification
Each command changes table state at the clock edge that samples it. The answer to a lookup or insert is registered at that same edge, so it is due exactly one cycle after the command. The bench drives each command on a falling edge and samples the outputs shortly after the next rising edge. An effect on the tables is checked through the port answer of a lookup issued on the following cycle. A wipe triggered by an insert is checked in the same way: the insert itself still shows the old answer, and the lookup one cycle later shows the cleared state.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_CHECK  = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_ISSUE  = 3'd4,
    OP_VIOL   = 3'd5,
    OP_SQUASH = 3'd6,
    OP_RSVD   = 3'd7
  } ss_op_e;
endpackage

// File: rtl/ss_id_table.sv
module ss_id_table #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned ID_W    = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_a_i,
  input  logic [IDX_W-1:0] rd_idx_b_i,
  output logic             rd_vld_a_o,
  output logic [ID_W-1:0]  rd_id_a_o,
  output logic             rd_vld_b_o,
  output logic [ID_W-1:0]  rd_id_b_o,
  input  logic             wr_a_i,
  input  logic [IDX_W-1:0] wr_idx_a_i,
  input  logic [ID_W-1:0]  wr_id_a_i,
  input  logic             wr_b_i,
  input  logic [IDX_W-1:0] wr_idx_b_i,
  input  logic [ID_W-1:0]  wr_id_b_i,
  input  logic             clr_all_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [ID_W-1:0]    id_q [ENTRIES];

  assign rd_vld_a_o = valid_q[rd_idx_a_i];
  assign rd_id_a_o  = id_q[rd_idx_a_i];
  assign rd_vld_b_o = valid_q[rd_idx_b_i];
  assign rd_id_b_o  = id_q[rd_idx_b_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < int'(ENTRIES); i++) id_q[i] <= '0;
    end else if (clr_all_i) begin
      valid_q <= '0;
    end else begin
      if (wr_b_i) begin
        valid_q[wr_idx_b_i] <= 1'b1;
        id_q[wr_idx_b_i]    <= wr_id_b_i;
      end
      // port a wins on an index collision
      if (wr_a_i) begin
        valid_q[wr_idx_a_i] <= 1'b1;
        id_q[wr_idx_a_i]    <= wr_id_a_i;
      end
    end
  end

  assert_write_a_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a_i && !clr_all_i |=> valid_q[$past(wr_idx_a_i)] && id_q[$past(wr_idx_a_i)] == $past(wr_id_a_i));

  assert_wipe_ids_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> valid_q == '0);
endmodule

// File: rtl/ss_last_store_table.sv
module ss_last_store_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned SEQ_W   = 16,
  localparam int unsigned ID_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  rd_id_i,
  output logic             rd_vld_o,
  output logic [SEQ_W-1:0] rd_seq_o,
  input  logic             wr_en_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic [SEQ_W-1:0] wr_seq_i,
  input  logic             inv_en_i,
  input  logic [ID_W-1:0]  inv_id_i,
  input  logic             squash_en_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic             clr_all_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [SEQ_W-1:0]   seq_q [ENTRIES];
  logic [ENTRIES-1:0] kill;

  assign rd_vld_o = valid_q[rd_id_i];
  assign rd_seq_o = seq_q[rd_id_i];

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_ent
    assign kill[g] = clr_all_i
                   || (squash_en_i && seq_q[g] > squash_seq_i)
                   || (inv_en_i && inv_id_i == ID_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        seq_q[g]   <= '0;
      end else if (kill[g]) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en_i && wr_id_i == ID_W'(g)) begin
        valid_q[g] <= 1'b1;
        seq_q[g]   <= wr_seq_i;
      end
    end

    assert_squash_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      squash_en_i |=> !(valid_q[g] && seq_q[g] > $past(squash_seq_i)));
  end

  assert_store_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !clr_all_i && !squash_en_i && !inv_en_i
    |=> valid_q[$past(wr_id_i)] && seq_q[$past(wr_id_i)] == $past(wr_seq_i));

  assert_issue_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_en_i |=> !valid_q[$past(inv_id_i)]);

  assert_wipe_last_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> valid_q == '0);
endmodule

// File: rtl/ss_clear_ctr.sv
module ss_clear_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             wipe_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W:0]   count_nx;

  assign count_nx = {1'b0, count_q} + 1'b1;
  // >= so a period lowered below the count still fires
  assign wipe_o = inc_i && (period_i != '0) && (count_nx >= {1'b0, period_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (wipe_o) count_q <= '0;
    else if (inc_i)  count_q <= count_nx[CNT_W-1:0];
  end

  assert_count_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_o |=> count_q == '0);

  assert_idle_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(count_q));
endmodule

// File: rtl/store_set_pred.sv
module store_set_pred #(
  parameter int unsigned PC_W         = 32,
  parameter int unsigned SEQ_W        = 16,
  parameter int unsigned SSIT_ENTRIES = 64,
  parameter int unsigned LFST_ENTRIES = 16,
  parameter int unsigned CNT_W        = 16,
  localparam int unsigned IDX_W = $clog2(SSIT_ENTRIES),
  localparam int unsigned ID_W  = $clog2(LFST_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  pc_load_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [CNT_W-1:0] clear_period_i,
  output logic             dep_valid_o,
  output logic [SEQ_W-1:0] dep_seq_o
);
  import ss_pkg::*;

  ss_op_e op;
  assign op = ss_op_e'(op_i);

  logic [PC_W-1:0]  fold_a, fold_b;
  logic [IDX_W-1:0] idx_a, idx_b;
  logic [ID_W-1:0]  fresh_id;

  assign fold_a   = pc_i ^ (pc_i >> 10);
  assign fold_b   = pc_load_i ^ (pc_load_i >> 10);
  assign idx_a    = fold_a[IDX_W-1:0];
  assign idx_b    = fold_b[IDX_W-1:0];
  assign fresh_id = fold_a[ID_W-1:0];

  logic            vld_a, vld_b;
  logic [ID_W-1:0] id_a, id_b;
  logic            ls_vld;
  logic [SEQ_W-1:0] ls_seq;
  logic            wipe;

  // violation merge
  logic            wr_a, wr_b;
  logic [ID_W-1:0] wr_id_a, wr_id_b;
  logic            is_viol;

  assign is_viol = (op == OP_VIOL);

  always_comb begin
    wr_a    = 1'b0;
    wr_b    = 1'b0;
    wr_id_a = fresh_id;
    wr_id_b = fresh_id;
    if (is_viol) begin
      unique case ({vld_a, vld_b})
        2'b00: begin
          wr_a = 1'b1;
          wr_b = 1'b1;
        end
        2'b10: begin
          wr_b    = 1'b1;
          wr_id_b = id_a;
        end
        2'b01: begin
          wr_a    = 1'b1;
          wr_id_a = id_b;
        end
        default: begin
          wr_a    = 1'b1;
          wr_b    = 1'b1;
          wr_id_a = (id_a < id_b) ? id_a : id_b;
          wr_id_b = wr_id_a;
        end
      endcase
    end
  end

  ss_id_table #(
    .ENTRIES (SSIT_ENTRIES),
    .ID_W    (ID_W)
  ) i_id_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_a_i (idx_a),
    .rd_idx_b_i (idx_b),
    .rd_vld_a_o (vld_a),
    .rd_id_a_o  (id_a),
    .rd_vld_b_o (vld_b),
    .rd_id_b_o  (id_b),
    .wr_a_i     (wr_a),
    .wr_idx_a_i (idx_a),
    .wr_id_a_i  (wr_id_a),
    .wr_b_i     (wr_b),
    .wr_idx_b_i (idx_b),
    .wr_id_b_i  (wr_id_b),
    .clr_all_i  (wipe)
  );

  logic ls_wr, ls_inv, is_lookup, hit;

  assign hit       = vld_a && ls_vld;
  assign is_lookup = (op == OP_CHECK) || (op == OP_LOAD) || (op == OP_STORE);
  assign ls_wr     = (op == OP_STORE) && vld_a;
  assign ls_inv    = (op == OP_ISSUE) && hit && (ls_seq == seq_i);

  ss_last_store_table #(
    .ENTRIES (LFST_ENTRIES),
    .SEQ_W   (SEQ_W)
  ) i_last_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_id_i      (id_a),
    .rd_vld_o     (ls_vld),
    .rd_seq_o     (ls_seq),
    .wr_en_i      (ls_wr),
    .wr_id_i      (id_a),
    .wr_seq_i     (seq_i),
    .inv_en_i     (ls_inv),
    .inv_id_i     (id_a),
    .squash_en_i  (op == OP_SQUASH),
    .squash_seq_i (seq_i),
    .clr_all_i    (wipe)
  );

  ss_clear_ctr #(
    .CNT_W (CNT_W)
  ) i_clear_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    ((op == OP_LOAD) || (op == OP_STORE)),
    .period_i (clear_period_i),
    .wipe_o   (wipe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dep_valid_o <= 1'b0;
      dep_seq_o   <= '0;
    end else begin
      dep_valid_o <= is_lookup && hit;
      dep_seq_o   <= (is_lookup && hit) ? ls_seq : '0;
    end
  end

  assert_quiet_after_other_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_lookup |=> !dep_valid_o && dep_seq_o == '0);

  assert_merge_same_id_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_viol && vld_a && vld_b |=> $past(id_a < id_b ? id_a : id_b) == $past(wr_id_b));
endmodule

// File: tb/test_store_set_pred.sv
module test_store_set_pred;
  localparam int PC_W = 32, SEQ_W = 16, CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0]       op_i = 3'd0;
  logic [PC_W-1:0]  pc_i = '0;
  logic [PC_W-1:0]  pc_load_i = '0;
  logic [SEQ_W-1:0] seq_i = '0;
  logic [CNT_W-1:0] clear_period_i = 16'd1000;
  logic             dep_valid_o;
  logic [SEQ_W-1:0] dep_seq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  store_set_pred i_store_set_pred (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .op_i           (op_i),
    .pc_i           (pc_i),
    .pc_load_i      (pc_load_i),
    .seq_i          (seq_i),
    .clear_period_i (clear_period_i),
    .dep_valid_o    (dep_valid_o),
    .dep_seq_o      (dep_seq_o)
  );

  localparam logic [2:0] NOP = 3'd0, CHK = 3'd1, LD = 3'd2, ST = 3'd3,
                         ISS = 3'd4, VIO = 3'd5, SQ = 3'd6;

  task automatic expect_rsp(string req, bit ev, logic [SEQ_W-1:0] es);
    checks++;
    if (dep_valid_o !== ev || dep_seq_o !== (ev ? es : '0)) begin
      errors++;
      $display("FAIL %s: got valid=%0b seq=%0d, expected valid=%0b seq=%0d",
               req, dep_valid_o, dep_seq_o, ev, ev ? es : 0);
    end
  endtask

  // drive on falling edge, sample 1 ns after the capturing rising edge
  task automatic cmd(logic [2:0] o, logic [PC_W-1:0] pc, logic [PC_W-1:0] pcl,
                     logic [SEQ_W-1:0] s);
    @(negedge clk);
    op_i = o; pc_i = pc; pc_load_i = pcl; seq_i = s;
    @(posedge clk);
    #1;
    @(negedge clk);
    op_i = NOP;
  endtask

  task automatic look(string req, logic [PC_W-1:0] pc, bit ev, logic [SEQ_W-1:0] es);
    cmd(CHK, pc, '0, '0);
    expect_rsp(req, ev, es);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    op_i = NOP;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    expect_rsp("R1 outputs after reset", 1'b0, '0);
    look("R1 empty tables", 32'h40, 1'b0, '0);
  endtask

  task automatic t_new_set();
    cmd(VIO, 32'h13, 32'h25, '0);          // store set 3
    expect_rsp("R12 quiet after violation", 1'b0, '0);
    cmd(ST, 32'h13, '0, 16'd10);
    expect_rsp("R4 first store no wait", 1'b0, '0);
    cmd(LD, 32'h25, '0, 16'd11);
    expect_rsp("R5 load waits on store", 1'b1, 16'd10);
    look("R6 load joined store set", 32'h25, 1'b1, 16'd10);
    look("R3 unmapped pc", 32'h99, 1'b0, '0);
    cmd(ST, 32'h77, '0, 16'd13);
    expect_rsp("R4 store without set", 1'b0, '0);
  endtask

  task automatic t_store_chain();
    cmd(ST, 32'h25, '0, 16'd12);
    expect_rsp("R4 store waits on previous", 1'b1, 16'd10);
    look("R4 last store replaced", 32'h13, 1'b1, 16'd12);
  endtask

  task automatic t_issue();
    cmd(ISS, 32'h25, '0, 16'd10);
    expect_rsp("R12 quiet after issue", 1'b0, '0);
    look("R9 stale issue ignored", 32'h13, 1'b1, 16'd12);
    cmd(ISS, 32'h13, '0, 16'd12);
    look("R9 matching issue clears", 32'h13, 1'b0, '0);
  endtask

  task automatic t_copy();
    cmd(VIO, 32'h13, 32'h31, '0);          // only store has id 3
    cmd(ST, 32'h13, '0, 16'd20);
    look("R7 id copied to load", 32'h31, 1'b1, 16'd20);
    cmd(VIO, 32'h3A, 32'h31, '0);          // only load has id 3
    look("R7 id copied to store", 32'h3A, 1'b1, 16'd20);
  endtask

  task automatic t_merge();
    cmd(VIO, 32'h07, 32'h08, '0);          // set 7
    cmd(VIO, 32'h07, 32'h31, '0);          // ids 7 and 3 -> 3
    look("R8 store pc takes smaller id", 32'h07, 1'b1, 16'd20);
    look("R8 load pc keeps smaller id", 32'h31, 1'b1, 16'd20);
    look("R8 untouched pc keeps id 7", 32'h08, 1'b0, '0);
  endtask

  task automatic t_squash();
    cmd(ST, 32'h08, '0, 16'd30);           // set 7 gets 30
    look("R10 younger entry present", 32'h08, 1'b1, 16'd30);
    cmd(SQ, '0, '0, 16'd25);
    expect_rsp("R12 quiet after squash", 1'b0, '0);
    look("R10 younger store removed", 32'h08, 1'b0, '0);
    look("R10 older store kept", 32'h13, 1'b1, 16'd20);
  endtask

  task automatic t_hash();
    do_reset();
    cmd(VIO, 32'h405, 32'h0C, '0);         // fold 0x405 -> idx 4, id 4
    cmd(ST, 32'h04, '0, 16'd50);           // idx 4 shares that entry
    look("R2 folded index and id", 32'h0C, 1'b1, 16'd50);
  endtask

  task automatic t_clear();
    do_reset();
    clear_period_i = 16'd3;
    cmd(VIO, 32'h13, 32'h25, '0);
    cmd(ST, 32'h13, '0, 16'd40);           // count 1
    cmd(LD, 32'h25, '0, 16'd41);           // count 2
    expect_rsp("R11 before clear", 1'b1, 16'd40);
    cmd(LD, 32'h25, '0, 16'd42);           // count 3 -> wipe
    expect_rsp("R11 wiping insert sees old state", 1'b1, 16'd40);
    look("R11 tables wiped", 32'h25, 1'b0, '0);
    cmd(VIO, 32'h13, 32'h25, '0);
    cmd(ST, 32'h13, '0, 16'd43);           // count 1 again
    look("R11 count restarted", 32'h25, 1'b1, 16'd43);
    do_reset();
    clear_period_i = 16'd0;
    cmd(VIO, 32'h13, 32'h25, '0);
    cmd(ST, 32'h13, '0, 16'd60);
    for (int i = 0; i < 6; i++) cmd(LD, 32'h25, '0, SEQ_W'(61 + i));
    look("R11 period zero never clears", 32'h25, 1'b1, 16'd60);
  endtask

  initial begin
    t_reset();
    t_new_set();
    t_store_chain();
    t_issue();
    t_copy();
    t_merge();
    t_squash();
    t_hash();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule